// File: doc/BRIEF.md
# Low-Power Residency Timer

This block measures how long a serial link has stayed in a low-power substate. While the link-state input reports the substate, it counts ticks of a free-running slow auxiliary clock (19.2 MHz nominal, about 52 ns per tick). When the count reaches a programmed limit, it raises an interrupt. A small register port on a separate bus clock holds the settings:

- a timer control word, with a counter-reset bit and a 31-bit tick limit;
- an event enable bit;
- a sticky interrupt status with its mask and its write-one-to-clear register.

Control bits reach the auxiliary domain through two-flop synchronizers. The timeout pulse comes back to the bus domain through a toggle synchronizer.

Software arms the timer with a fixed sequence:

1. Write the control word with the reset bit set.
2. Wait at least three auxiliary cycles.
3. Write the reset bit together with the new limit.
4. Wait at least one more auxiliary cycle.
5. Write the limit alone, which releases the reset.
6. Set the enable bit.

To disarm, clear the enable bit and write zero to the control word. The default 100 ms threshold is 1,920,000 ticks. The register port carries no streamed data, so every pin is a plain control or status pin. A write takes effect on the bus clock edge on which `wr_en` is high, and reads are combinational.

Top module: `lpr_residency_timer`

## Requirements
- R1: After reset, the control, enable, status and mask registers all read zero, and `irq_o` is low.
- R2: With limit N > 0, the reset bit clear and the enable bit set, the timeout happens on the Nth auxiliary tick of an unbroken stay in the substate. Status bit 3 (register at offset 0x08) sets a few bus cycles after that tick.
- R3: Leaving the substate returns the count to zero, so stays shorter than N ticks never set the status, however many of them occur.
- R4: The timeout fires at most once per stay. After status is cleared, remaining in the same stay never sets it again.
- R5: With bit 0 of the enable register (offset 0x04) clear, a timeout leaves the status unchanged.
- R6: `irq_o` is high exactly when some status bit is set whose mask bit (register at offset 0x0C) is also set. A masked event still sets status.
- R7: Writing the clear register (offset 0x10) clears each status bit written as one and leaves the bits written as zero.
- R8: While bit 31 of the control register (offset 0x00) is set, the counter holds at zero and no timeout occurs. After release, a full N ticks are needed.
- R9: A limit of zero, including the all-zero disarm value, never produces a timeout.
- R10: The control and enable registers read back the last value written to them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bus_clk | input | 1 | Register bus clock |
| bus_rst_n | input | 1 | Asynchronous active-low reset, bus domain |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 5 | Write byte offset |
| wr_data | input | 32 | Write data |
| rd_addr | input | 5 | Read byte offset |
| rd_data | output | 32 | Combinational read data |
| aux_clk | input | 1 | Free-running auxiliary tick clock |
| aux_rst_n | input | 1 | Asynchronous active-low reset, auxiliary domain |
| link_lp_i | input | 1 | Link in the low-power substate, synchronous to `aux_clk` |
| irq_o | output | 1 | Interrupt, OR of unmasked status bits |

## Verification
A counter that fails to clear on leaving the substate shows up as a status bit set after a series of short stays; an off-by-one limit compare shows up as status appearing one tick early or late, within the two-tick window around tick N. A lost "already fired" flag shows up as a second status set within N ticks of a clear while the stay continues. Mask or enable faults show on `irq_o` or the status bit within a few bus cycles of the tick.

// File: rtl/lpr_pkg.sv
package lpr_pkg;
  localparam int ADDR_W      = 5;
  localparam int DATA_W      = 32;
  localparam int STAT_W      = 8;
  localparam int TIMEOUT_BIT = 3;
  localparam int CNT_W       = DATA_W - 1;
  localparam int RST_BIT     = DATA_W - 1;

  localparam logic [ADDR_W-1:0] OFS_CTRL = 5'h00;
  localparam logic [ADDR_W-1:0] OFS_EN   = 5'h04;
  localparam logic [ADDR_W-1:0] OFS_STAT = 5'h08;
  localparam logic [ADDR_W-1:0] OFS_MASK = 5'h0C;
  localparam logic [ADDR_W-1:0] OFS_CLR  = 5'h10;
endpackage

// File: rtl/lpr_vec_sync.sv
module lpr_vec_sync #(
  parameter int W      = 32,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] chain_q;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q[s] <= '0;
        else if (s == 0) chain_q[s] <= d_i;
        else chain_q[s] <= chain_q[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/lpr_pulse_xfer.sv
module lpr_pulse_xfer #(
  parameter int STAGES = 3
) (
  input  logic src_clk,
  input  logic src_rst_n,
  input  logic src_pulse_i,
  input  logic dst_clk,
  input  logic dst_rst_n,
  output logic dst_pulse_o
);
  logic              tog_q;
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge src_clk or negedge src_rst_n) begin
    if (!src_rst_n) tog_q <= 1'b0;
    else if (src_pulse_i) tog_q <= ~tog_q;
  end

  always_ff @(posedge dst_clk or negedge dst_rst_n) begin
    if (!dst_rst_n) sync_q <= '0;
    else sync_q <= {sync_q[STAGES-2:0], tog_q};
  end

  assign dst_pulse_o = sync_q[STAGES-1] ^ sync_q[STAGES-2];
endmodule

// File: rtl/lpr_res_counter.sv
module lpr_res_counter
  import lpr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lp_i,
  input  logic             clr_i,
  input  logic [CNT_W-1:0] max_i,
  output logic             pulse_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_nxt;
  logic             fired_q;
  logic             armed;

  assign cnt_nxt = cnt_q + 1'b1;
  assign armed   = !fired_q && (max_i != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      fired_q <= 1'b0;
      pulse_o <= 1'b0;
    end else if (clr_i || !lp_i) begin
      cnt_q   <= '0;
      fired_q <= 1'b0;
      pulse_o <= 1'b0;
    end else begin
      pulse_o <= 1'b0;
      if (armed) begin
        cnt_q <= cnt_nxt;
        if (cnt_nxt == max_i) begin
          pulse_o <= 1'b1;
          fired_q <= 1'b1;
        end
      end
    end
  end

  a_r3_leave_zeroes: assert property (@(posedge clk) disable iff (!rst_n)
    !lp_i |=> (cnt_q == '0));
  a_r8_reset_holds: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (cnt_q == '0) && !pulse_o);
  a_r4_single_fire: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_o |=> !pulse_o);
  a_r9_zero_limit: assert property (@(posedge clk) disable iff (!rst_n)
    (max_i == '0) |=> !pulse_o);
endmodule

// File: rtl/lpr_reg_bank.sv
module lpr_reg_bank
  import lpr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  input  logic              ev_i,
  output logic [DATA_W-1:0] ctrl_o,
  output logic              irq_o
);
  logic [DATA_W-1:0] ctrl_q;
  logic              en_q;
  logic [STAT_W-1:0] stat_q;
  logic [STAT_W-1:0] mask_q;
  logic [STAT_W-1:0] set_vec;
  logic [STAT_W-1:0] clr_vec;

  always_comb begin
    set_vec = '0;
    set_vec[TIMEOUT_BIT] = ev_i && en_q;
    clr_vec = (wr_en && wr_addr == OFS_CLR) ? wr_data[STAT_W-1:0] : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      en_q   <= 1'b0;
      mask_q <= '0;
      stat_q <= '0;
    end else begin
      if (wr_en && wr_addr == OFS_CTRL) ctrl_q <= wr_data;
      if (wr_en && wr_addr == OFS_EN)   en_q   <= wr_data[0];
      if (wr_en && wr_addr == OFS_MASK) mask_q <= wr_data[STAT_W-1:0];
      stat_q <= (stat_q & ~clr_vec) | set_vec;
    end
  end

  always_comb begin
    rd_data = '0;
    unique case (rd_addr)
      OFS_CTRL: rd_data = ctrl_q;
      OFS_EN:   rd_data[0] = en_q;
      OFS_STAT: rd_data[STAT_W-1:0] = stat_q;
      OFS_MASK: rd_data[STAT_W-1:0] = mask_q;
      default:  rd_data = '0;
    endcase
  end

  assign ctrl_o = ctrl_q;
  assign irq_o  = |(stat_q & mask_q);

  a_r5_enable_gates: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat_q[TIMEOUT_BIT]) |-> $past(en_q));
  a_r7_clear_works: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == OFS_CLR && wr_data[TIMEOUT_BIT] && !(ev_i && en_q))
    |=> !stat_q[TIMEOUT_BIT]);
  a_r6_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == '0) |-> !irq_o);
endmodule

// File: rtl/lpr_residency_timer.sv
module lpr_residency_timer
  import lpr_pkg::*;
(
  input  logic              bus_clk,
  input  logic              bus_rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  input  logic              aux_clk,
  input  logic              aux_rst_n,
  input  logic              link_lp_i,
  output logic              irq_o
);
  logic [DATA_W-1:0] ctrl_bus;
  logic [DATA_W-1:0] ctrl_aux;
  logic              ev_aux;
  logic              ev_bus;

  lpr_reg_bank u_regs (
    .clk     (bus_clk),
    .rst_n   (bus_rst_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .rd_addr (rd_addr),
    .rd_data (rd_data),
    .ev_i    (ev_bus),
    .ctrl_o  (ctrl_bus),
    .irq_o   (irq_o)
  );

  lpr_vec_sync #(.W(DATA_W), .STAGES(2)) u_ctrl_sync (
    .clk   (aux_clk),
    .rst_n (aux_rst_n),
    .d_i   (ctrl_bus),
    .q_o   (ctrl_aux)
  );

  lpr_res_counter u_cnt (
    .clk     (aux_clk),
    .rst_n   (aux_rst_n),
    .lp_i    (link_lp_i),
    .clr_i   (ctrl_aux[RST_BIT]),
    .max_i   (ctrl_aux[CNT_W-1:0]),
    .pulse_o (ev_aux)
  );

  lpr_pulse_xfer #(.STAGES(3)) u_ev_xfer (
    .src_clk     (aux_clk),
    .src_rst_n   (aux_rst_n),
    .src_pulse_i (ev_aux),
    .dst_clk     (bus_clk),
    .dst_rst_n   (bus_rst_n),
    .dst_pulse_o (ev_bus)
  );
endmodule

// File: tb/lpr_residency_timer_test.sv
module lpr_residency_timer_test;
  logic        bus_clk = 0, aux_clk = 0;
  logic        bus_rst_n = 0, aux_rst_n = 0;
  logic        wr_en = 0;
  logic [4:0]  wr_addr = 0, rd_addr = 0;
  logic [31:0] wr_data = 0;
  logic [31:0] rd_data;
  logic        link_lp_i = 0;
  logic        irq_o;

  int tests = 0, fails = 0;
  int m_state = 0;   // 0 clear, 1 set, 2 unknown
  bit m_mask = 0;
  bit done = 0;

  localparam int N = 20;

  lpr_residency_timer uut (.*);

  always #4 bus_clk = ~bus_clk;
  always #26 aux_clk = ~aux_clk;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [4:0] a, logic [31:0] d);
    @(negedge bus_clk); wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge bus_clk); wr_en = 0;
  endtask

  task automatic rd(logic [4:0] a, output logic [31:0] d);
    @(negedge bus_clk); rd_addr = a; #1 d = rd_data;
  endtask

  task automatic aux_wait(int n);
    repeat (n) @(negedge aux_clk);
  endtask

  task automatic chk_stat(string req, bit exp);
    logic [31:0] v;
    rd(5'h08, v);
    chk(req, {31'b0, v[3]}, {31'b0, exp});
  endtask

  task automatic clear_stat();
    wr(5'h10, 32'h8);
    m_state = 0;
  endtask

  // reference: per-clock irq expectation (R6)
  always @(negedge bus_clk) begin
    #2;
    if (bus_rst_n && !done) begin
      if (!m_mask) chk("R6 masked irq", {31'b0, irq_o}, 32'h0);
      else if (m_state != 2) chk("R6 irq", {31'b0, irq_o}, {31'b0, m_state == 1});
    end
  end

  initial begin
    #200000;
    tests++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [31:0] v;
    #30; bus_rst_n = 1; aux_rst_n = 1;
    // R1 reset state
    rd(5'h00, v); chk("R1 ctrl", v, 0);
    rd(5'h04, v); chk("R1 en", v, 0);
    rd(5'h08, v); chk("R1 status", v, 0);
    rd(5'h0C, v); chk("R1 mask", v, 0);
    chk("R1 irq", {31'b0, irq_o}, 0);

    // arm sequence, R10 readback
    wr(5'h0C, 32'h8); m_mask = 1;
    wr(5'h00, 32'h8000_0000); aux_wait(4);
    wr(5'h00, 32'h8000_0000 | N); aux_wait(2);
    wr(5'h00, N); aux_wait(3);
    wr(5'h04, 32'h1);
    rd(5'h00, v); chk("R10 ctrl", v, N);
    rd(5'h04, v); chk("R10 en", v, 1);

    // R2 threshold timing
    m_state = 2;
    link_lp_i = 1;
    aux_wait(N - 1); chk_stat("R2 before limit", 0);
    aux_wait(3); chk_stat("R2 after limit", 1);
    m_state = 1;
    aux_wait(1);

    // R4 fires once per stay
    clear_stat();
    aux_wait(2 * N); chk_stat("R4 no refire", 0);
    link_lp_i = 0; aux_wait(2);

    // R3 short stays restart the count
    for (int k = 0; k < 3; k++) begin
      link_lp_i = 1; aux_wait(N - 3);
      link_lp_i = 0; aux_wait(2);
    end
    chk_stat("R3 short stays", 0);
    m_state = 2;
    link_lp_i = 1; aux_wait(N + 5);
    chk_stat("R3 full stay", 1);
    m_state = 1;
    link_lp_i = 0; aux_wait(2);

    // R7 write-one-to-clear
    wr(5'h10, 32'h0000_00F7);
    chk_stat("R7 zero bit kept", 1);
    clear_stat();
    chk_stat("R7 one bit cleared", 0);

    // R6 masked event still sets status
    wr(5'h0C, 32'h0); m_mask = 0;
    link_lp_i = 1; aux_wait(N + 5);
    chk_stat("R6 masked status", 1);
    chk("R6 masked irq low", {31'b0, irq_o}, 0);
    m_state = 1;
    wr(5'h0C, 32'h8); m_mask = 1;
    chk("R6 unmasked irq", {31'b0, irq_o}, 1);
    clear_stat();
    link_lp_i = 0; aux_wait(2);

    // R5 enable gate
    wr(5'h04, 32'h0);
    link_lp_i = 1; aux_wait(N + 5);
    chk_stat("R5 disabled", 0);
    link_lp_i = 0; aux_wait(2);
    wr(5'h04, 32'h1);

    // R8 reset bit holds counter
    wr(5'h00, 32'h8000_0000 | N); aux_wait(4);
    link_lp_i = 1; aux_wait(2 * N);
    chk_stat("R8 held in reset", 0);
    m_state = 2;
    wr(5'h00, N);
    aux_wait(N - 2); chk_stat("R8 full count after release", 0);
    aux_wait(8); chk_stat("R8 fires after release", 1);
    m_state = 1;
    clear_stat();
    link_lp_i = 0; aux_wait(2);

    // R9 disarm: zero limit never fires
    wr(5'h04, 32'h0); wr(5'h00, 32'h0);
    rd(5'h00, v); chk("R9 ctrl zero", v, 0);
    wr(5'h04, 32'h1); aux_wait(3);
    link_lp_i = 1; aux_wait(2 * N);
    chk_stat("R9 zero limit", 0);
    link_lp_i = 0; aux_wait(2);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule